// File: doc/BRIEF.md
# Three-Class Pairwise Linear SVM Classifier

This block classifies one feature vector into one of three classes. It runs three binary linear support-vector machines side by side: class 1 against 2, class 1 against 3, and class 2 against 3. Each machine has its own support-vector table and its own table of merged coefficients. Each coefficient is the class label already multiplied by the training multiplier. The tables are built at elaboration from parameters.

Every cycle, one machine takes one stored support vector and forms its full inner product with the test vector. A separate lane handles each feature dimension, and an adder tree sums the lanes. The machine scales that product by the entry's coefficient and adds the result to a running sum. After the last entry it adds a bias and takes the sign. The three signs are counted as votes, and the class with the most votes is reported.

A host holds a vector on the input and pulses `start` while `ready` is high. It then waits for the one-cycle `class_valid` pulse.

Top module: `svm_tri_class`

## Requirements
- R1: After a synchronous active-low reset, `ready` is high and `class_valid` is low.
- R2: All values are signed 24-bit fixed point with 16 fraction bits. A lane product is the full 48-bit product shifted right arithmetically by 16, keeping the low 24 bits. The inner product is the sum of the seven lane products, wrapping in 24 bits. Test-vector element d occupies bits [24d+23:24d] of `x_vec`.
- R3: For machine k (0 = 1v2, 1 = 1v3, 2 = 2v3), element d of support vector i equals (((31i + 17d + 53k) mod 128) − 64) × 1024.
- R4: The coefficient of entry i of machine k equals (((13i + 29k + 7) mod 64) − 32) × 512. The term added for that entry is the inner product times the coefficient, truncated as in R2.
- R5: Each machine clears its sum when a vector is accepted. It adds exactly one term per table entry, and the tables hold 70, 13 and 68 entries for machines 0, 1 and 2.
- R6: After the last term, the bias is added with 24-bit wrap. The biases are −0.7890625, +0.25 and −0.125. A sum that is not negative votes for the lower class of the pair, and a negative sum votes for the higher class. `pair_sign[k]` is 1 when machine k voted for its lower class.
- R7: `class_id` (1, 2 or 3) names the class that received two votes, and `tie` is low.
- R8: When each class receives exactly one vote, `class_id` is 1 and `tie` is high.
- R9: `class_valid` is high for exactly one cycle. It follows the 76th rising edge after the edge that accepted the vector, which is the largest table size plus 6.
- R10: A `start` pulse while `ready` is low is ignored. It changes neither the result nor the number of `class_valid` pulses.
- R11: `ready` goes low on the edge that accepts a vector and returns high together with `class_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept `x_vec` when `ready` is high |
| x_vec | input | 168 | Seven packed signed 24-bit test elements |
| ready | output | 1 | Idle and able to accept a vector |
| class_valid | output | 1 | One-cycle pulse marking a result |
| class_id | output | 2 | Winning class, 1 to 3 |
| tie | output | 1 | All three classes got one vote |
| pair_sign | output | 3 | Per-machine votes, 1 = lower class |

## Verification
Almost any internal fault ends in a wrong class or a wrong tie flag, visible on the single `class_valid` cycle of the vector that exercised it. Each vector gives one result per run of about 76 cycles. `pair_sign` shows which machine is at fault. Faults in the table contents, a lane, truncation or the bias move the sign of a machine's sum. An all-zero vector isolates the biases, because it makes every sum equal to its bias. Faults in the counter, the flag delays or the handshake move `class_valid` off edge 76, or they let a start that arrives mid-run alter the outcome.

// File: rtl/svm_pkg.sv
// Package: shared types and codes for the three-class pairwise SVM.
// Assumes classes are numbered 1..3 and code 0 is never produced.
package svm_pkg;
    typedef logic [1:0] class_t;
    localparam class_t CLS_A = 2'd1;
    localparam class_t CLS_B = 2'd2;
    localparam class_t CLS_C = 2'd3;
    localparam int N_PAIRS   = 3;
endpackage

// File: rtl/svm_lane_dot.sv
// Module: per-dimension multiply lanes followed by an adder tree.
// Computes the truncated fixed-point inner product of two vectors with a
// two-cycle latency (product register, then sum register).
// Assumes both operands are packed signed words, element d at [d*W +: W].
module svm_lane_dot #(
    parameter int NDIM = 7,
    parameter int W    = 24,
    parameter int FRAC = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NDIM*W-1:0]        a_i,
    input  logic [NDIM*W-1:0]        b_i,
    output logic signed [W-1:0]      dot_o
);
    function automatic logic signed [W-1:0] qmul(input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b);
        logic signed [2*W-1:0] p;
        p = a * b;
        return p[FRAC+W-1:FRAC];
    endfunction

    logic signed [W-1:0] prod_q [NDIM];
    logic signed [W-1:0] tree_sum;

    for (genvar g = 0; g < NDIM; g++) begin : g_lane
        // Lane register: one truncated product per dimension.
        always_ff @(posedge clk) begin
            if (!rst_n) prod_q[g] <= '0;
            else        prod_q[g] <= qmul(a_i[g*W +: W], b_i[g*W +: W]);
        end
    end

    // Adder tree: wrapping sum of all lane products.
    always_comb begin
        tree_sum = '0;
        for (int d = 0; d < NDIM; d++) tree_sum = tree_sum + prod_q[d];
    end

    // Sum register: completes the inner-product stage.
    always_ff @(posedge clk) begin
        if (!rst_n) dot_o <= '0;
        else        dot_o <= tree_sum;
    end
endmodule

// File: rtl/svm_pair_engine.sv
// Module: one binary linear SVM machine.
// Walks its support-vector table one entry per cycle, scales each inner
// product by the merged coefficient, accumulates, adds the bias and
// reports the sign. Table contents are computed at elaboration from KSEED.
// Assumes start_i arrives only while the machine is idle and that x_i stays
// stable for the whole run.
module svm_pair_engine #(
    parameter int NDIM  = 7,
    parameter int W     = 24,
    parameter int FRAC  = 16,
    parameter int NSV   = 70,
    parameter int BIAS  = -51712,
    parameter int KSEED = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NDIM*W-1:0] x_i,
    output logic              done_o,
    output logic              sign_o
);
    localparam int ROWW = NDIM * W;
    localparam int IW   = (NSV > 1) ? $clog2(NSV) : 1;
    localparam logic [IW-1:0]   LAST_IDX = IW'(NSV - 1);
    localparam logic signed [W-1:0] BIAS_W = W'(BIAS);

    function automatic logic signed [W-1:0] qmul(input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b);
        logic signed [2*W-1:0] p;
        p = a * b;
        return p[FRAC+W-1:FRAC];
    endfunction

    logic [ROWW-1:0]     sv_rom   [NSV];
    logic signed [W-1:0] coef_rom [NSV];

    for (genvar i = 0; i < NSV; i++) begin : g_row
        localparam int CRAW = ((i*13 + KSEED*29 + 7) % 64) - 32;
        assign coef_rom[i] = W'(CRAW * 512);
        for (genvar d = 0; d < NDIM; d++) begin : g_col
            localparam int SRAW = ((i*31 + d*17 + KSEED*53) % 128) - 64;
            assign sv_rom[i][d*W +: W] = W'(SRAW * 1024);
        end
    end

    logic [IW-1:0]       idx;
    logic                running;
    logic [ROWW-1:0]     sv_q;
    logic signed [W-1:0] c_q [3];
    logic [3:0]          vld;
    logic [3:0]          lst;
    logic signed [W-1:0] dot;
    logic signed [W-1:0] term_q;
    logic signed [W-1:0] acc;
    logic                fin_pend;
    logic signed [W-1:0] total;

    // Address counter: one table entry per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            running <= 1'b0;
        end else if (start_i) begin
            idx     <= '0;
            running <= 1'b1;
        end else if (running) begin
            if (idx == LAST_IDX) running <= 1'b0;
            else                 idx     <= idx + 1'b1;
        end
    end

    // Table read plus flag and coefficient delay line matching the lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_q <= '0;
            vld  <= '0;
            lst  <= '0;
            for (int s = 0; s < 3; s++) c_q[s] <= '0;
        end else begin
            sv_q   <= sv_rom[idx];
            c_q[0] <= coef_rom[idx];
            c_q[1] <= c_q[0];
            c_q[2] <= c_q[1];
            vld    <= {vld[2:0], running};
            lst    <= {lst[2:0], running && (idx == LAST_IDX)};
        end
    end

    svm_lane_dot #(.NDIM(NDIM), .W(W), .FRAC(FRAC)) u_dot (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (x_i),
        .b_i   (sv_q),
        .dot_o (dot)
    );

    // Coefficient scaling stage.
    always_ff @(posedge clk) begin
        if (!rst_n) term_q <= '0;
        else        term_q <= qmul(dot, c_q[2]);
    end

    assign total = acc + BIAS_W;

    // Serial accumulator and final sign decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            fin_pend <= 1'b0;
            done_o   <= 1'b0;
            sign_o   <= 1'b0;
        end else if (start_i) begin
            acc      <= '0;
            fin_pend <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            if (vld[3]) acc <= acc + term_q;
            fin_pend <= vld[3] && lst[3];
            if (fin_pend) begin
                done_o <= 1'b1;
                sign_o <= ~total[W-1];
            end
        end
    end

    // R5: the counter never addresses beyond the table.
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (idx <= LAST_IDX));
    // R5: the sum is cleared after a vector is accepted.
    p_acc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (acc == '0 && !done_o));
    // R9: a result only appears once the walk has ended.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (!running && vld == '0));
endmodule

// File: rtl/svm_vote.sv
// Module: pairwise vote counter for three classes.
// Input s[k] = 1 means machine k picked the lower class of its pair
// (pairs 1v2, 1v3, 2v3). Purely combinational.
module svm_vote
    import svm_pkg::*;
(
    input  logic [N_PAIRS-1:0] s_i,
    output class_t             cls_o,
    output logic               tie_o
);
    logic [1:0] n1, n2, n3;

    // Count votes for each class and pick the one with two.
    always_comb begin
        n1 = 2'(s_i[0]) + 2'(s_i[1]);
        n2 = 2'(!s_i[0]) + 2'(s_i[2]);
        n3 = 2'(!s_i[1]) + 2'(!s_i[2]);
        tie_o = 1'b0;
        if (n1 == 2'd2)      cls_o = CLS_A;
        else if (n2 == 2'd2) cls_o = CLS_B;
        else if (n3 == 2'd2) cls_o = CLS_C;
        else begin
            cls_o = CLS_A;
            tie_o = 1'b1;
        end
    end
endmodule

// File: rtl/svm_tri_class.sv
// Module: three-class pairwise linear SVM classifier (top).
// Captures a test vector on an accepted start, runs three binary machines
// in parallel on it, and pulses class_valid with the voted class once all
// three have finished. Assumes the host waits for ready before starting.
module svm_tri_class
    import svm_pkg::*;
#(
    parameter int NDIM    = 7,
    parameter int W       = 24,
    parameter int FRAC    = 16,
    parameter int NSV_12  = 70,
    parameter int NSV_13  = 13,
    parameter int NSV_23  = 68,
    parameter int BIAS_12 = -51712,
    parameter int BIAS_13 = 16384,
    parameter int BIAS_23 = -8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NDIM*W-1:0] x_vec,
    output logic              ready,
    output logic              class_valid,
    output logic [1:0]        class_id,
    output logic              tie,
    output logic [2:0]        pair_sign
);
    localparam int XW = NDIM * W;

    logic              busy;
    logic              accept;
    logic [XW-1:0]     x_q;
    logic [N_PAIRS-1:0] done;
    logic [N_PAIRS-1:0] sgn;
    logic              all_done_q;
    logic              finish;
    class_t            vote_cls;
    logic              vote_tie;

    assign ready  = !busy;
    assign accept = start && !busy;
    assign finish = (&done) && !all_done_q;

    // Handshake: capture the vector and hold busy until the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            x_q  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            x_q  <= x_vec;
        end else if (finish) begin
            busy <= 1'b0;
        end
    end

    svm_pair_engine #(.NDIM(NDIM), .W(W), .FRAC(FRAC), .NSV(NSV_12),
                      .BIAS(BIAS_12), .KSEED(0)) u_m12 (
        .clk(clk), .rst_n(rst_n), .start_i(accept), .x_i(x_q),
        .done_o(done[0]), .sign_o(sgn[0]));
    svm_pair_engine #(.NDIM(NDIM), .W(W), .FRAC(FRAC), .NSV(NSV_13),
                      .BIAS(BIAS_13), .KSEED(1)) u_m13 (
        .clk(clk), .rst_n(rst_n), .start_i(accept), .x_i(x_q),
        .done_o(done[1]), .sign_o(sgn[1]));
    svm_pair_engine #(.NDIM(NDIM), .W(W), .FRAC(FRAC), .NSV(NSV_23),
                      .BIAS(BIAS_23), .KSEED(2)) u_m23 (
        .clk(clk), .rst_n(rst_n), .start_i(accept), .x_i(x_q),
        .done_o(done[2]), .sign_o(sgn[2]));

    svm_vote u_vote (.s_i(sgn), .cls_o(vote_cls), .tie_o(vote_tie));

    // Result register: one valid pulse when the last machine finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_done_q  <= 1'b0;
            class_valid <= 1'b0;
            class_id    <= '0;
            tie         <= 1'b0;
            pair_sign   <= '0;
        end else begin
            all_done_q  <= &done;
            class_valid <= finish;
            if (finish) begin
                class_id  <= vote_cls;
                tie       <= vote_tie;
                pair_sign <= sgn;
            end
        end
    end

    // R9: the valid pulse lasts a single cycle.
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        class_valid |=> !class_valid);
    // R7: a reported class is always a legal code.
    p_class_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        class_valid |-> (class_id != 2'd0));
    // R8: a tie always reports class 1.
    p_tie_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (class_valid && tie) |-> (class_id == 2'd1));
    // R10: a start while busy leaves the captured vector alone.
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(x_q));
    // R11: ready returns exactly with the result.
    p_ready_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> class_valid);
endmodule

// File: tb/sim_svm_tri_class.sv
// Bench: fixed-seed random and directed vectors checked against a
// bench-side model built from the requirement formulas.
module sim_svm_tri_class;
    localparam int NDIM = 7;
    localparam int W    = 24;
    localparam int NSV [3] = '{70, 13, 68};
    localparam int BIAS[3] = '{-51712, 16384, -8192};
    localparam int LAT  = 76;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NDIM*W-1:0] x_vec = '0;
    logic ready, class_valid, tie;
    logic [1:0] class_id;
    logic [2:0] pair_sign;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    svm_tri_class u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .x_vec(x_vec),
        .ready(ready), .class_valid(class_valid), .class_id(class_id),
        .tie(tie), .pair_sign(pair_sign));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R2 truncated multiply.
    function automatic logic signed [23:0] qm(input logic signed [23:0] a,
                                              input logic signed [23:0] b);
        logic signed [47:0] p;
        p = 48'(a) * 48'(b);
        return p[39:16];
    endfunction

    // R3 table element.
    function automatic logic signed [23:0] sv_el(input int k, input int i, input int d);
        return 24'((((i*31 + d*17 + k*53) % 128) - 64) * 1024);
    endfunction

    // R4 coefficient.
    function automatic logic signed [23:0] cf_el(input int k, input int i);
        return 24'((((i*13 + k*29 + 7) % 64) - 32) * 512);
    endfunction

    // R5/R6 machine sign: 1 means vote for the lower class.
    function automatic bit m_sign(input int k, input logic [NDIM*W-1:0] x);
        logic signed [23:0] acc, dot, tot;
        acc = '0;
        for (int i = 0; i < NSV[k]; i++) begin
            dot = '0;
            for (int d = 0; d < NDIM; d++) dot = dot + qm(x[d*W +: W], sv_el(k, i, d));
            acc = acc + qm(dot, cf_el(k, i));
        end
        tot = acc + 24'(BIAS[k]);
        return !tot[23];
    endfunction

    // R7/R8 vote model: returns {tie, class[1:0]}.
    function automatic logic [2:0] vote(input logic [2:0] s);
        int n1, n2, n3;
        n1 = int'(s[0]) + int'(s[1]);
        n2 = int'(!s[0]) + int'(s[2]);
        n3 = int'(!s[1]) + int'(!s[2]);
        if (n1 == 2) return 3'b0_01;
        if (n2 == 2) return 3'b0_10;
        if (n3 == 2) return 3'b0_11;
        return 3'b1_01;
    endfunction

    // Run one vector; optionally poke start mid-run with another vector.
    task automatic run(input logic [NDIM*W-1:0] x, input bit poke, input string tag);
        logic [2:0] es, ev;
        int n;
        bit seen;
        for (int k = 0; k < 3; k++) es[k] = m_sign(k, x);
        ev = vote(es);
        @(negedge clk);
        check(ready, "R11 ready before start", int'(ready), 1);
        start = 1'b1;
        x_vec = x;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(!ready, "R11 ready low after accept", int'(ready), 0);
        n = 0;
        seen = 0;
        while (!seen && n < 200) begin
            if (poke && n == 20) begin
                start = 1'b1;
                x_vec = ~x;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            if (class_valid) seen = 1;
        end
        check(n == LAT, {"R9 latency ", tag}, n, LAT);
        check(ready, {"R11 ready with valid ", tag}, int'(ready), 1);
        check(pair_sign == es, {"R6 pair signs ", tag}, int'(pair_sign), int'(es));
        check(class_id == ev[1:0], {"R7 class ", tag}, int'(class_id), int'(ev[1:0]));
        check(tie == ev[2], {"R8 tie ", tag}, int'(tie), int'(ev[2]));
        @(negedge clk);
        check(!class_valid, {"R9 single pulse ", tag}, int'(class_valid), 0);
    endtask

    initial begin
        logic [NDIM*W-1:0] x;
        int unused_seed;
        unused_seed = $urandom(32'h5a17);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready, "R1 ready after reset", int'(ready), 1);
        check(!class_valid, "R1 no valid after reset", int'(class_valid), 0);

        // Zero vector: every sum equals its bias -> signs 0,1,0 -> tie (R6, R8).
        run('0, 0, "zero");
        check(pair_sign == 3'b010, "R6 bias-only signs", int'(pair_sign), 2);
        check(tie && class_id == 2'd1, "R8 tie on zero vector", int'(class_id), 1);

        // Extreme constant vectors (R2 wrap paths).
        for (int d = 0; d < NDIM; d++) x[d*W +: W] = 24'sh7FFFFF;
        run(x, 0, "max");
        for (int d = 0; d < NDIM; d++) x[d*W +: W] = 24'sh800000;
        run(x, 0, "min");

        // R10: start while busy is ignored.
        for (int d = 0; d < NDIM; d++) x[d*W +: W] = 24'(int'($urandom % 131072) - 65536);
        run(x, 1, "busy-start");
        repeat (90) begin
            @(negedge clk);
            if (class_valid) check(0, "R10 extra valid", 1, 0);
        end

        // Random vectors in [-1, 1) (R2..R7).
        for (int t = 0; t < 40; t++) begin
            for (int d = 0; d < NDIM; d++) x[d*W +: W] = 24'(int'($urandom % 131072) - 65536);
            run(x, 0, "rand");
        end
        // Wider random vectors in [-4, 4).
        for (int t = 0; t < 20; t++) begin
            for (int d = 0; d < NDIM; d++) x[d*W +: W] = 24'(int'($urandom % 524288) - 262144);
            run(x, 0, "wide");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule